// File: doc/BRIEF.md
# Multi-Channel RC Servo Pulse Generator

This block drives a bank of RC servo outputs from a single system clock. Every timing value is a count of clock ticks, which are 20 ns at 50 MHz. All channels share one frame length. A typical frame is 1,000,000 ticks, or 20 ms. Each channel has its own pulse width, for example 75,000 ticks for a 1.5 ms pulse. At the start of every frame, each enabled channel raises its output and holds it high for the programmed number of ticks.

A host programs the block through a small synchronous register port. The port gives access to the frame length, one width register per channel and a configuration word. The configuration word carries the channel enables and a master enable, and it reads back, so the host can change one channel's enable by read-modify-write. New frame lengths and widths are staged and take effect only at a frame boundary, so a running frame is never shortened. Clearing the master enable forces every output low and parks the frame counter at zero.

Top module: `servo_pulse_bank`

## Requirements
- R1: While reset is held (synchronous, active low) and after it is released, every output is low and every register reads zero.
- R2: Register map on `reg_addr`: 0 is the frame length (20 bits, zero-extended on read), 1 is the configuration word, and 2+n is channel n's width (20 bits). A written value reads back in the following cycle. Addresses 10 to 15 read zero and ignore writes.
- R3: In the configuration word, bit n (n = 0 to 7) enables channel n and bit 16 is the master enable. All other bits read zero. A channel output can be high only when its own bit and bit 16 are both set, and a change takes effect in the cycle after the write.
- R4: With the master enable set and a frame length P, a frame lasts exactly P cycles, tick 0 to P-1. An enabled channel of width W is high during the ticks below W.
- R5: A written frame length or width is applied at the first frame boundary strictly after the write cycle. The frame in progress completes with the old values.
- R6: A width equal to or above the frame length keeps the output high for the whole frame. A width of zero keeps it low.
- R7: While the master enable is clear, all outputs are low, the frame counter is held at zero, and staged values are copied in every cycle. After re-enabling, the first frame starts at tick 0 with the latest values.
- R8: Channels are independent: each follows only its own width and enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| servo_out | output | 8 | Pulse outputs, bit n is channel n |

## Verification
Read data depends only on the address and the register contents, so the bench checks it 1 ns after moving the address at a falling edge. A configuration write shows on `servo_out` directly after the rising edge that takes the write. A frame-length or width write shows only after the first wrap edge that follows the write edge, where the active copies load and the counter returns to zero. The bench keeps a cycle model that is advanced on every rising edge from these rules. It compares all eight outputs against that model at every falling edge, so each result is checked in the cycle it is due, under directed corner cases and under random register traffic.

// File: rtl/servo_pkg.sv
// Package: shared register map constants for the servo pulse bank.
// Assumes: word-addressed register port, one register per address.
package servo_pkg;
    localparam int ADDR_PERIOD  = 0;   // shared frame length
    localparam int ADDR_CONFIG  = 1;   // channel enables plus master enable
    localparam int ADDR_ON_BASE = 2;   // channel n width lives at base + n
    localparam int MASTER_BIT   = 16;  // master enable position in config
endpackage

// File: rtl/servo_regs.sv
// Module: servo_regs
// Holds the host-visible staging registers and the configuration word,
// decodes writes and serves combinational read-back.
// Assumes: NUM_CH + ADDR_ON_BASE <= 2**ADDR_W and NUM_CH <= MASTER_BIT < DATA_W.
module servo_regs
    import servo_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [CNT_W-1:0]              stage_period,
    output logic [NUM_CH-1:0][CNT_W-1:0]  stage_on,
    output logic [NUM_CH-1:0]             ch_en,
    output logic                          master_en
);
    // Decode host writes into the staging and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_period <= '0;
            stage_on     <= '0;
            ch_en        <= '0;
            master_en    <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_PERIOD)) begin
                stage_period <= wdata[CNT_W-1:0];
            end
            if (addr == ADDR_W'(ADDR_CONFIG)) begin
                ch_en     <= wdata[NUM_CH-1:0];
                master_en <= wdata[MASTER_BIT];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(ADDR_ON_BASE + i)) begin
                    stage_on[i] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    // Select the read-back word for the presented address.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_PERIOD)) begin
            rdata[CNT_W-1:0] = stage_period;
        end
        if (addr == ADDR_W'(ADDR_CONFIG)) begin
            rdata[NUM_CH-1:0]  = ch_en;
            rdata[MASTER_BIT]  = master_en;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(ADDR_ON_BASE + i)) begin
                rdata[CNT_W-1:0] = stage_on[i];
            end
        end
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_CONFIG)) |=> (master_en == $past(wdata[MASTER_BIT]))); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (master_en == 1'b0 && ch_en == '0)); // R1
endmodule

// File: rtl/servo_frame_timer.sv
// Module: servo_frame_timer
// Shared frame counter. It counts ticks 0..P-1 while the master enable
// is set, and it raises a load strobe at each frame boundary and in
// every cycle while disabled.
// Assumes: a frame length of 0 or 1 gives a one-tick frame.
module servo_frame_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] stage_period,
    output logic [CNT_W-1:0] tick,
    output logic             load
);
    logic [CNT_W-1:0] act_period;
    logic             wrap;

    // Detect the last tick of the frame; the sum is widened so the top value cannot overflow.
    always_comb begin
        wrap = ({1'b0, tick} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, act_period};
        load = !run || wrap;
    end

    // Advance, wrap or park the frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || wrap) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // Copy the staged frame length at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
        end else if (load) begin
            act_period <= stage_period;
        end
    end

    AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (act_period != '0) |-> (tick < act_period)); // R4
    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tick == '0)); // R7
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_period)); // R5
endmodule

// File: rtl/servo_channel.sv
// Module: servo_channel
// One output: it holds the active width, reloaded at frame boundaries,
// and compares it with the shared tick.
// Assumes: tick restarts at zero at the start of every frame.
module servo_channel #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             enable,
    input  logic [CNT_W-1:0] tick,
    input  logic [CNT_W-1:0] stage_on,
    output logic             pulse
);
    logic [CNT_W-1:0] act_on;

    // Copy the staged width at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on <= '0;
        end else if (load) begin
            act_on <= stage_on;
        end
    end

    // Drive the pulse high for ticks below the active width.
    always_comb begin
        pulse = enable && (tick < act_on);
    end

    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_on)); // R5
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on == '0) |-> !pulse); // R6
endmodule

// File: rtl/servo_pulse_bank.sv
// Module: servo_pulse_bank (top)
// Bank of servo pulse outputs that share one frame counter. A register
// port stages the frame length and widths. The configuration word gates
// each channel and the whole bank.
// Assumes: a single clock domain; the host port is synchronous to clk.
module servo_pulse_bank
    import servo_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] servo_out
);
    logic [CNT_W-1:0]             stage_period;
    logic [NUM_CH-1:0][CNT_W-1:0] stage_on;
    logic [NUM_CH-1:0]            ch_en;
    logic                         master_en;
    logic [CNT_W-1:0]             tick;
    logic                         load;

    servo_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .stage_period (stage_period),
        .stage_on     (stage_on),
        .ch_en        (ch_en),
        .master_en    (master_en)
    );

    servo_frame_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (master_en),
        .stage_period (stage_period),
        .tick         (tick),
        .load         (load)
    );

    // One comparator per channel, all fed by the shared tick.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        servo_channel #(
            .CNT_W (CNT_W)
        ) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .enable   (master_en && ch_en[g]),
            .tick     (tick),
            .stage_on (stage_on[g]),
            .pulse    (servo_out[g])
        );
    end

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (servo_out == '0)); // R7
    AST_CHANNEL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_out & ~ch_en) == '0); // R3
endmodule

// File: tb/test_servo_pulse_bank.sv
// Bench: directed corner cases plus seeded random register traffic,
// compared every cycle against a cycle model built from the requirements.
module test_servo_pulse_bank;
    localparam int NCH = 8;
    localparam int CW  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  servo_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R4";

    // Model state, advanced from the requirements.
    logic [CW-1:0]          m_per_s, m_per_a, m_cnt;
    logic [NCH-1:0][CW-1:0] m_on_s, m_on_a;
    logic [NCH-1:0]         m_en;
    logic                   m_gen;

    servo_pulse_bank i_servo_pulse_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .servo_out (servo_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int n = 0; n < NCH; n++) r[n] = m_gen && m_en[n] && (m_cnt < m_on_a[n]);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        logic [31:0] r = '0;
        if (a == 4'd0) r[CW-1:0] = m_per_s;
        else if (a == 4'd1) begin r[NCH-1:0] = m_en; r[16] = m_gen; end
        else if (a >= 4'd2 && a < 4'd10) r[CW-1:0] = m_on_s[a-4'd2];
        return r;
    endfunction

    // Cycle model: frames, boundary loads and register writes (R2..R7).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_per_s <= '0; m_per_a <= '0; m_cnt <= '0;
            m_on_s <= '0; m_on_a <= '0; m_en <= '0; m_gen <= 1'b0;
        end else begin
            logic wrapv;
            wrapv = ({1'b0, m_cnt} + 21'd1) >= {1'b0, m_per_a};
            if (!m_gen || wrapv) m_cnt <= '0; else m_cnt <= m_cnt + 1'b1;
            if (!m_gen || wrapv) begin m_per_a <= m_per_s; m_on_a <= m_on_s; end
            if (reg_wr) begin
                if (reg_addr == 4'd0) m_per_s <= reg_wdata[CW-1:0];
                else if (reg_addr == 4'd1) begin m_en <= reg_wdata[7:0]; m_gen <= reg_wdata[16]; end
                else if (reg_addr >= 4'd2 && reg_addr < 4'd10) m_on_s[reg_addr-4'd2] <= reg_wdata[CW-1:0];
            end
        end
    end

    // Per-cycle output comparison (R3, R4, R8 and the phase tag).
    always @(negedge clk) begin
        if (rst_n && cmp_on) check(cur_tag, {24'd0, servo_out}, {24'd0, exp_out()});
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {24'd0, servo_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'd0, servo_out}, 32'd0);
        reg_addr = 4'd0; #1; check("R1", reg_rdata, 32'd0);
        reg_addr = 4'd1; #1; check("R1", reg_rdata, 32'd0);
        reg_addr = 4'd5; #1; check("R1", reg_rdata, 32'd0);
        cmp_on = 1'b1;

        // R2: map, readback, truncation and unmapped addresses
        cur_tag = "R2";
        wr(4'd0, 32'hFFF0_000A);
        rd_check("R2", 4'd0);
        check("R2", reg_rdata, 32'h0000_000A);
        wr(4'd5, 32'd4);
        rd_check("R2", 4'd5);
        wr(4'd12, 32'hFFFF_FFFF);
        rd_check("R2", 4'd12);
        check("R2", reg_rdata, 32'd0);
        wr(4'd1, 32'hFFFF_FFFF);
        rd_check("R3", 4'd1);
        check("R3", reg_rdata, 32'h0001_00FF);
        wr(4'd1, 32'd0);

        // R4 and R8: distinct widths per channel, frame length 10
        cur_tag = "R4";
        wr(4'd2, 32'd3);  wr(4'd3, 32'd7);  wr(4'd4, 32'd1);
        wr(4'd6, 32'd9);  wr(4'd7, 32'd5);  wr(4'd8, 32'd2);  wr(4'd9, 32'd6);
        wr(4'd1, 32'h0001_00FF);
        idle(35);
        cur_tag = "R8";
        wr(4'd1, 32'h0001_0055);
        idle(25);

        // R6: width zero and width above the frame length
        cur_tag = "R6";
        wr(4'd2, 32'd0); wr(4'd3, 32'd10); wr(4'd4, 32'd200);
        wr(4'd1, 32'h0001_0007);
        idle(30);
        check("R6", {31'd0, servo_out[1] & servo_out[2]}, 32'd1);
        check("R6", {31'd0, servo_out[0]}, 32'd0);

        // R5: mid-frame update of the frame length and a width
        cur_tag = "R5";
        wr(4'd0, 32'd20); wr(4'd2, 32'd5); wr(4'd1, 32'h0001_0001);
        idle(27);
        wr(4'd0, 32'd30);
        idle(3);
        wr(4'd2, 32'd12);
        idle(70);

        // R7: master disable parks everything, then restart
        cur_tag = "R7";
        wr(4'd1, 32'h0000_00FF);
        check("R7", {24'd0, servo_out}, 32'd0);
        wr(4'd0, 32'd8); wr(4'd2, 32'd3);
        idle(5);
        check("R7", {24'd0, servo_out}, 32'd0);
        wr(4'd1, 32'h0001_00FF);
        check("R7", {31'd0, servo_out[0]}, 32'd1);
        idle(20);

        // Random register traffic under the cycle model
        cur_tag = "R4";
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) begin
                logic [3:0] a;
                logic [31:0] d;
                a = 4'($urandom_range(11));
                d = $urandom();
                if (a == 4'd0) d = $urandom_range(40, 2);
                else if (a == 4'd1) d = {15'd0, ($urandom_range(4) != 0), 8'd0, d[7:0]};
                else if (a < 4'd10) d = $urandom_range(45);
                reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
            end else begin
                reg_wr = 1'b0;
                reg_addr = 4'($urandom_range(15));
                #1;
                check("R2", reg_rdata, exp_read(reg_addr));
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
        idle(5);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule